// File: doc/BRIEF.md
# Legacy Display Host Write Mapper

This block sits between a CPU-side write port and a frame buffer arranged as 32-bit words, each word holding four byte-wide planes. A CPU write of one, two or four bytes is accepted in a single cycle. The block then issues it as a run of single-byte writes, one per clock cycle, at consecutive host byte addresses. Each byte is checked against the selected legacy display memory window. On a hit it becomes one frame buffer word write. The byte value is copied onto every lane, and four byte enables pick which planes take it.

The word address and the byte enables depend on the write mode. Normal mode passes the host address straight through and uses the plane mask as the enables. Odd/even mode steers even bytes to planes 0 and 2 and odd bytes to planes 1 and 3, and puts the page bit into address bit 0. Chain-4 mode steers each byte to a single plane chosen by the two low address bits, and clears those two address bits. The plane mask gates the address-derived enables in both of these modes. The window select, mode controls, plane mask and page bit are configuration inputs. The system holds them steady while the block is busy, and the block reads them in the cycle each byte is issued.

Top module: `lgd_host_wr_mapper`

## Requirements
- R1: After reset, and with no request pending, `busy` and `fb_we` are low.
- R2: A request accepted on a clock edge is issued as byte writes in the following cycles, one per cycle. `req_size` 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 gives 4 bytes. Byte k goes to host byte address `req_addr`+k and carries `req_data` bits [8k+7:8k]. `busy` is high in every issue cycle and low in the cycle after the last one.
- R3: A `req_valid` pulse while `busy` is high is ignored. The bytes in progress keep their addresses and data, and no extra writes follow.
- R4: A byte writes the frame buffer (`fb_we` high) only if its host address is in the selected window. `win_sel` 0 selects 000A0000h–000AFFFFh, 1 selects 000B0000h–000B7FFFh, 2 selects 000B8000h–000BFFFFh, and 3 selects no window.
- R5: In normal mode (`mode_oe`=0, `mode_c4`=0), `fb_addr` is host address bits [15:0] and `fb_be` equals `plane_mask`.
- R6: In odd/even mode (`mode_oe`=1, `mode_c4`=0), `fb_be` is 0101b when host bit 0 is 0 and 1010b when it is 1, ANDed with `plane_mask`. `fb_addr` is host bits [15:1] with `page_bit` as bit 0.
- R7: In chain-4 mode (`mode_c4`=1, whatever `mode_oe` is), `fb_be` has only bit n set, where n is host bits [1:0], ANDed with `plane_mask`. `fb_addr` is host bits [15:2] followed by two zero bits.
- R8: `fb_wdata` carries the issued byte on all four lanes: bits [7:0], [15:8], [23:16] and [31:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host write request, taken when not busy |
| req_addr | input | 32 | Host byte address of the first byte |
| req_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_data | input | 32 | Write data, byte k in bits [8k+7:8k] |
| win_sel | input | 2 | Decoded memory window select |
| mode_oe | input | 1 | Odd/even write mode enable |
| mode_c4 | input | 1 | Chain-4 write mode enable, overrides odd/even |
| plane_mask | input | 4 | Plane write mask |
| page_bit | input | 1 | Replacement address bit 0 in odd/even mode |
| busy | output | 1 | A byte write is being issued this cycle |
| fb_we | output | 1 | Frame buffer write strobe |
| fb_addr | output | 16 | Frame buffer word address |
| fb_be | output | 4 | Frame buffer byte (plane) enables |
| fb_wdata | output | 32 | Frame buffer write data, byte replicated |

## Verification
The bench builds the block with its default parameters: four byte lanes, a 16-bit word address and 32-bit host addresses. With only four planes, every plane mask value, every window select, every combination of the two mode controls and every access size can be swept. Each combination is run against host addresses placed at and just beyond the window edges, so that multi-byte accesses crossing a window boundary and every low-address lane position are covered. A separate run sends a second request in the middle of a four-byte access, to show that it is dropped.

// File: rtl/lgd_pkg.sv
package lgd_pkg;

  localparam int LGD_LANES  = 4;
  localparam int LGD_IDX_W  = 2;
  localparam int LGD_LANE_W = 8;

  typedef enum logic [1:0] {
    WIN_A_64K = 2'd0,
    WIN_B_LO  = 2'd1,
    WIN_B_HI  = 2'd2,
    WIN_NONE  = 2'd3
  } win_sel_e;

  typedef enum logic [1:0] {
    WM_NORMAL = 2'd0,
    WM_ODDEVEN = 2'd1,
    WM_CHAIN4 = 2'd2
  } wr_mode_e;

  // index of the final byte of an access of the given size code
  function automatic logic [LGD_IDX_W-1:0] size_last_idx(input logic [1:0] sz);
    case (sz)
      2'd0:    size_last_idx = 2'd0;
      2'd1:    size_last_idx = 2'd1;
      default: size_last_idx = 2'd3;
    endcase
  endfunction

  // chain-4 moves chooses one lane from the two low address bits
  function automatic logic [LGD_LANES-1:0] chain4_lanes(input logic [1:0] lo);
    logic [LGD_LANES-1:0] r;
    for (int i = 0; i < LGD_LANES; i++) r[i] = (lo == i[1:0]);
    return r;
  endfunction

  // odd/even picks the even lane pair or the odd lane pair
  function automatic logic [LGD_LANES-1:0] oddeven_lanes(input logic b0);
    logic [LGD_LANES-1:0] r;
    for (int i = 0; i < LGD_LANES; i++) r[i] = (i[0] == b0);
    return r;
  endfunction

  function automatic wr_mode_e resolve_mode(input logic oe, input logic c4);
    if (c4)      return WM_CHAIN4;
    else if (oe) return WM_ODDEVEN;
    else         return WM_NORMAL;
  endfunction

endpackage

// File: rtl/lgd_byte_sequencer.sv
module lgd_byte_sequencer
  import lgd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [1:0]                   req_size,
  input  logic [LGD_LANES*LGD_LANE_W-1:0] req_data,
  output logic                         active,
  output logic                         last_byte,
  output logic [ADDR_W-1:0]            cur_addr,
  output logic [LGD_LANE_W-1:0]        cur_byte
);
  localparam int DATA_W = LGD_LANES * LGD_LANE_W;

  logic [LGD_IDX_W-1:0] idx_q, last_q;
  logic [ADDR_W-1:0]    base_q;
  logic [DATA_W-1:0]    data_q;
  logic                 accept;

  assign accept    = req_valid && !active;
  assign last_byte = active && (idx_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      base_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      active <= 1'b1;
      idx_q  <= '0;
      last_q <= size_last_idx(req_size);
      base_q <= req_addr;
      data_q <= req_data;
    end else if (active) begin
      if (last_byte) active <= 1'b0;
      else           idx_q  <= idx_q + 1'b1;
    end
  end

  assign cur_addr = base_q + ADDR_W'(idx_q);

  always_comb begin
    cur_byte = '0;
    for (int i = 0; i < LGD_LANES; i++)
      if (idx_q == i[LGD_IDX_W-1:0]) cur_byte = data_q[i*LGD_LANE_W +: LGD_LANE_W];
  end

  // R2: a run that has bytes left stays active and steps by one byte
  p_run_continues_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last_byte) |=> (active && idx_q == $past(idx_q) + 1'b1));
  // R2: the last byte ends the run
  p_run_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> !active);
  // R3: a run in progress keeps its captured address and data
  p_hold_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last_byte) |=> ($stable(base_q) && $stable(data_q) && $stable(last_q)));

endmodule

// File: rtl/lgd_window_decode.sv
module lgd_window_decode
  import lgd_pkg::*;
#(
  parameter int             ADDR_W    = 32,
  parameter logic [31:0]    BASE_A    = 32'h000A_0000,
  parameter logic [31:0]    BASE_B_LO = 32'h000B_0000,
  parameter logic [31:0]    BASE_B_HI = 32'h000B_8000,
  parameter int             SPAN_A_W  = 16,
  parameter int             SPAN_B_W  = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        win_sel,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] MASK_A = ~((ADDR_W'(1) << SPAN_A_W) - 1'b1);
  localparam logic [ADDR_W-1:0] MASK_B = ~((ADDR_W'(1) << SPAN_B_W) - 1'b1);

  logic in_a, in_b_lo, in_b_hi;

  assign in_a    = (addr & MASK_A) == ADDR_W'(BASE_A);
  assign in_b_lo = (addr & MASK_B) == ADDR_W'(BASE_B_LO);
  assign in_b_hi = (addr & MASK_B) == ADDR_W'(BASE_B_HI);

  always_comb begin
    case (win_sel_e'(win_sel))
      WIN_A_64K: hit = in_a;
      WIN_B_LO:  hit = in_b_lo;
      WIN_B_HI:  hit = in_b_hi;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/lgd_lane_mapper.sv
module lgd_lane_mapper
  import lgd_pkg::*;
#(
  parameter int FB_AW = 16
) (
  input  logic [FB_AW-1:0]     byte_addr,
  input  logic                 mode_oe,
  input  logic                 mode_c4,
  input  logic [LGD_LANES-1:0] plane_mask,
  input  logic                 page_bit,
  output logic [FB_AW-1:0]     word_addr,
  output logic [LGD_LANES-1:0] lane_en
);
  wr_mode_e mode;
  assign mode = resolve_mode(mode_oe, mode_c4);

  always_comb begin
    case (mode)
      WM_CHAIN4: begin
        word_addr = {byte_addr[FB_AW-1:2], 2'b00};
        lane_en   = chain4_lanes(byte_addr[1:0]) & plane_mask;
      end
      WM_ODDEVEN: begin
        word_addr = {byte_addr[FB_AW-1:1], page_bit};
        lane_en   = oddeven_lanes(byte_addr[0]) & plane_mask;
      end
      default: begin
        word_addr = byte_addr;
        lane_en   = plane_mask;
      end
    endcase
  end

endmodule

// File: rtl/lgd_host_wr_mapper.sv
module lgd_host_wr_mapper
  import lgd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FB_AW  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_data,
  input  logic [1:0]  win_sel,
  input  logic        mode_oe,
  input  logic        mode_c4,
  input  logic [3:0]  plane_mask,
  input  logic        page_bit,
  output logic        busy,
  output logic        fb_we,
  output logic [15:0] fb_addr,
  output logic [3:0]  fb_be,
  output logic [31:0] fb_wdata
);
  logic                  seq_active, seq_last, win_hit;
  logic [ADDR_W-1:0]     seq_addr;
  logic [LGD_LANE_W-1:0] seq_byte;
  logic [FB_AW-1:0]      map_addr;
  logic [LGD_LANES-1:0]  map_en;

  lgd_byte_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_data  (req_data),
    .active    (seq_active),
    .last_byte (seq_last),
    .cur_addr  (seq_addr),
    .cur_byte  (seq_byte)
  );

  lgd_window_decode #(.ADDR_W(ADDR_W)) u_win (
    .addr    (seq_addr),
    .win_sel (win_sel),
    .hit     (win_hit)
  );

  lgd_lane_mapper #(.FB_AW(FB_AW)) u_map (
    .byte_addr  (seq_addr[FB_AW-1:0]),
    .mode_oe    (mode_oe),
    .mode_c4    (mode_c4),
    .plane_mask (plane_mask),
    .page_bit   (page_bit),
    .word_addr  (map_addr),
    .lane_en    (map_en)
  );

  assign busy    = seq_active;
  assign fb_we   = seq_active && win_hit;
  assign fb_addr = map_addr;
  assign fb_be   = map_en;

  genvar g;
  generate
    for (g = 0; g < LGD_LANES; g++) begin : g_lane
      assign fb_wdata[g*LGD_LANE_W +: LGD_LANE_W] = seq_byte;
    end
  endgenerate

  // R1: no write strobe without an issuing byte
  p_we_needs_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> busy);
  // R4: the disabled window never writes
  p_no_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_sel == 2'd3) |-> !fb_we);
  // R7: chain-4 enables at most one plane on a word-aligned address
  p_c4_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && mode_c4) |-> ($countones(fb_be) <= 1 && fb_addr[1:0] == 2'b00));
  // R6: odd/even places the page bit at address bit 0
  p_oe_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && mode_oe && !mode_c4) |-> (fb_addr[0] == page_bit));
  // R6 R7: enables never reach a plane the mask excludes
  p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> ((fb_be & ~plane_mask) == 4'b0000));
  // R8: every lane carries the same byte
  p_lanes_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> (fb_wdata[31:8] == {3{fb_wdata[7:0]}}));

endmodule

// File: tb/lgd_host_wr_mapper_tb.sv
module lgd_host_wr_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_data = '0;
  logic [1:0]  win_sel = '0;
  logic        mode_oe = 1'b0;
  logic        mode_c4 = 1'b0;
  logic [3:0]  plane_mask = '0;
  logic        page_bit = 1'b0;
  logic        busy, fb_we;
  logic [15:0] fb_addr;
  logic [3:0]  fb_be;
  logic [31:0] fb_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lgd_host_wr_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_data(req_data), .win_sel(win_sel),
    .mode_oe(mode_oe), .mode_c4(mode_c4), .plane_mask(plane_mask),
    .page_bit(page_bit), .busy(busy), .fb_we(fb_we), .fb_addr(fb_addr),
    .fb_be(fb_be), .fb_wdata(fb_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [31:0] a, input logic [1:0] w);
    case (w)
      2'd0: return a >= 32'h000A0000 && a <= 32'h000AFFFF;
      2'd1: return a >= 32'h000B0000 && a <= 32'h000B7FFF;
      2'd2: return a >= 32'h000B8000 && a <= 32'h000BFFFF;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] pick_addr(input int i);
    case (i)
      0: return 32'h000A0000;
      1: return 32'h000A1235;
      2: return 32'h000AFFFE;
      3: return 32'h000B7FFD;
      4: return 32'h000B8002;
      5: return 32'h000BFFFF;
      6: return 32'h0009FFFE;
      default: return 32'h010A0003;
    endcase
  endfunction

  // expected outcome of one issued byte, written from the requirements
  task automatic check_byte(input logic [31:0] a, input logic [7:0] b, input string tag);
    logic [3:0]  e_be;
    logic [15:0] e_addr;
    string       mreq;
    bit          e_we;
    e_we = exp_hit(a, win_sel);
    if (mode_c4) begin
      mreq = "R7"; e_be = (4'b0001 << a[1:0]) & plane_mask; e_addr = a[15:0] & 16'hFFFC;
    end else if (mode_oe) begin
      mreq = "R6"; e_be = (a[0] ? 4'b1010 : 4'b0101) & plane_mask;
      e_addr = (a[15:0] & 16'hFFFE) | {15'd0, page_bit};
    end else begin
      mreq = "R5"; e_be = plane_mask; e_addr = a[15:0];
    end
    chk({"R2 busy ", tag}, {31'd0, busy}, 32'd1);
    chk({"R4 we ", tag}, {31'd0, fb_we}, {31'd0, e_we});
    if (e_we) begin
      chk({mreq, " addr ", tag}, {16'd0, fb_addr}, {16'd0, e_addr});
      chk({mreq, " be ", tag}, {28'd0, fb_be}, {28'd0, e_be});
      chk({"R8 data ", tag}, fb_wdata, 32'h01010101 * {24'd0, b});
    end
  endtask

  // drive one access at a falling edge; returns at the falling edge after the run
  task automatic run_access(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      check_byte(a + k, d[8*k +: 8], "sweep");
      @(negedge clk);
    end
    chk("R2 idle after run", {30'd0, busy, fb_we}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2 actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {30'd0, busy, fb_we}, 32'd0);

    // sweep: windows x modes x masks x addresses x sizes
    for (int w = 0; w < 4; w++)
      for (int m = 0; m < 4; m++)
        for (int pm = 0; pm < 16; pm++)
          for (int ai = 0; ai < 8; ai++)
            for (int sz = 0; sz < 4; sz++) begin
              win_sel = w[1:0]; mode_oe = m[0]; mode_c4 = m[1];
              plane_mask = pm[3:0]; page_bit = pm[0] ^ ai[0] ^ sz[0];
              run_access(pick_addr(ai), sz[1:0], 32'hA1B2C3D4 ^ {pm[3:0], 4'd0, ai[7:0], sz[7:0], w[3:0], m[3:0]});
            end

    // R3: a request during a 4-byte run is dropped
    win_sel = 2'd0; mode_oe = 1'b0; mode_c4 = 1'b0; plane_mask = 4'hF; page_bit = 1'b0;
    req_valid = 1'b1; req_addr = 32'h000A0100; req_size = 2'd2; req_data = 32'h44332211;
    @(negedge clk);
    req_addr = 32'h000A0F00; req_size = 2'd0; req_data = 32'h000000EE;
    for (int k = 0; k < 4; k++) begin
      chk("R3 addr kept", {16'd0, fb_addr}, {16'd0, 16'h0100 + k[15:0]});
      chk("R3 data kept", fb_wdata, 32'h01010101 * (32'h11 * (k + 1)));
      @(negedge clk);
      if (k == 2) req_valid = 1'b0;
    end
    chk("R3 no extra write", {30'd0, busy, fb_we}, 32'd0);
    @(negedge clk);
    chk("R3 still idle", {30'd0, busy, fb_we}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule